// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Stretch Tolerance

This block produces the SCL waveform of an I2C master from a down-counting baud timer. A programmable 7-bit reload value sets the length of each SCL phase. The timer steps once every second system clock. The block drives SCL low for one phase. It then releases the line and waits until the line is really high before it times the high phase. A slave that holds SCL low therefore lengthens the period, and the high time that follows always lasts one complete count.

A higher-level sequencer asserts the enable to run the clock. It uses the release request to decide when a low phase may end, which lets it hold SCL low while it sets up data, a repeated START or a STOP. The same release-and-wait rule applies to every release. The sampled SCL line passes through a two-stage synchroniser before the block uses it. A status flag reports the time during which the released line is still seen low. A one-cycle strobe marks every point where the count reaches zero.

Top module: `i2c_scl_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), scl_drive_low, rollover and stretch_flag are all 0.
- R2: While enable is 0, SCL stays released (scl_drive_low = 0) and rollover stays 0. From the first clock edge at which enable is 1, SCL is driven low.
- R3: Let N be the effective reload value. The timer steps once every second clock, and a low phase drives SCL low for exactly 2N+1 clock cycles when release_req is held at 1.
- R4: With no external stretching and the line following the drive, each released period lasts exactly 2N+4 clock cycles: two synchroniser cycles, one reload cycle, and a high phase of 2N+1 cycles.
- R5: While SCL is released but still seen low, the timer is frozen. After the line rises, SCL stays released for exactly 2N+3 more cycles, however long the stretch lasted.
- R6: Once the low-phase count has reached zero, the count holds at zero and SCL stays low for as long as release_req is 0. SCL is released one cycle after release_req becomes 1.
- R7: stretch_flag is 1 exactly while SCL is released and the synchronised line is low. It is 0 whenever SCL is driven low or the high phase is being timed. An unstretched period shows it for 2 cycles.
- R8: rollover pulses high for one cycle each time the count steps to zero. A full SCL period gives exactly two pulses, and the low-phase pulse falls in the last driven-low cycle.
- R9: A reload value of 0 behaves as 1, which gives a low phase of 3 cycles and a released period of 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reload_val | input | 7 | Phase length value N (0 treated as 1) |
| enable | input | 1 | Run the SCL clock; 0 returns to idle with SCL released |
| release_req | input | 1 | Permits the low phase to end once its count is done |
| scl_in | input | 1 | Raw SCL line level (asynchronous) |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release (open drain) |
| rollover | output | 1 | One-cycle strobe when the count reaches zero |
| stretch_flag | output | 1 | Released SCL still seen low (waiting or stretched) |

## Verification
A counter that steps on the wrong tick, or that is reloaded too early or too late, shows up in the first phase after the fault as a low or released duration that differs from 2N+1 or 2N+4 cycles. A counter that keeps running during the wait shows up in the first stretched period, because the high time measured after the line rises falls short of 2N+3 cycles. A wrong phase state appears within one cycle as a drive level, a stretch flag or a rollover count that does not fit the phase the port waveform shows.

// File: rtl/i2c_scl_pkg.sv
// Shared types and helpers for the SCL clock generator.
package i2c_scl_pkg;

    // Phase of the SCL generator.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,  // disabled, SCL released
        PH_LOW   = 2'd1,  // SCL driven low, timing low phase
        PH_WAITH = 2'd2,  // SCL released, waiting to see it high
        PH_HIGH  = 2'd3   // SCL released and high, timing high phase
    } scl_phase_e;

endpackage

// File: rtl/i2c_scl_tick.sv
// Step enable for the baud timer: a divide-by-two toggle.
// Assumes: restart is pulsed on every reload, so each phase starts at the same tick alignment.
module i2c_scl_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    logic tick_q;

    // Toggle every clock while timing; hold low when idle or on reload.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) tick_q <= 1'b0;
        else                           tick_q <= ~tick_q;
    end

    assign tick = tick_q;
endmodule

// File: rtl/i2c_scl_sync.sv
// Multi-stage synchroniser for the asynchronous SCL line level.
// Assumes: the idle line is high, so every stage resets to 1.
module i2c_scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the register chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_scl_baud.sv
// Down-counting baud timer. Loads the effective reload value (0 becomes 1),
// steps on dec_en, holds at zero until the next load, and strobes on reaching zero.
// Assumes: load and dec_en come from the phase controller; load wins.
module i2c_scl_baud #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic             cnt_zero,
    output logic             roll
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_val;
    logic             roll_q;

    // Reload value of zero is promoted to one.
    assign eff_val = (reload_val == '0) ? ONE : reload_val;

    // Counter: load, step down, or hold (including hold-off at zero).
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (load)                     cnt_q <= eff_val;
        else if (dec_en && cnt_q != '0)    cnt_q <= cnt_q - ONE;
    end

    // Rollover strobe registered on the step into zero.
    always_ff @(posedge clk) begin
        if (!rst_n) roll_q <= 1'b0;
        else        roll_q <= dec_en && !load && (cnt_q == ONE);
    end

    assign cnt_zero = (cnt_q == '0);
    assign roll     = roll_q;

    // R6: once at zero the count stays there until a load.
    assert_holdoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> (cnt_q == '0));
    // R9: a load never leaves the counter at zero.
    assert_min_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0));
    // R8: the strobe lasts a single cycle.
    assert_roll_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        roll_q |=> !roll_q);
endmodule

// File: rtl/i2c_scl_gen.sv
// SCL clock generator top. Sequences idle, low, wait-for-high and high phases.
// Times each phase with the baud timer and freezes while released SCL is held low.
// Assumes: scl_in is the raw wired-AND line level; scl_drive_low drives an open-drain pad.
module i2c_scl_gen #(
    parameter int CNT_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             enable,
    input  logic             release_req,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             rollover,
    output logic             stretch_flag
);
    import i2c_scl_pkg::*;

    scl_phase_e ph_q, ph_d;
    logic       load;
    logic       timing;
    logic       tick;
    logic       dec_en;
    logic       cnt_zero;
    logic       scl_seen;

    i2c_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (scl_in),
        .sync_out (scl_seen)
    );

    assign timing = (ph_q == PH_LOW) || (ph_q == PH_HIGH);

    i2c_scl_tick u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timing),
        .restart (load),
        .tick    (tick)
    );

    assign dec_en = tick && timing;

    i2c_scl_baud #(.CNT_W(CNT_W)) u_baud (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .dec_en     (dec_en),
        .reload_val (reload_val),
        .cnt_zero   (cnt_zero),
        .roll       (rollover)
    );

    // Next phase and reload decision.
    always_comb begin
        ph_d = ph_q;
        load = 1'b0;
        case (ph_q)
            PH_IDLE:  if (enable) begin ph_d = PH_LOW; load = 1'b1; end
            PH_LOW:   if (cnt_zero && release_req) ph_d = PH_WAITH;
            PH_WAITH: if (scl_seen) begin ph_d = PH_HIGH; load = 1'b1; end
            PH_HIGH:  if (cnt_zero) begin ph_d = PH_LOW; load = 1'b1; end
            default:  ph_d = PH_IDLE;
        endcase
        if (!enable) begin
            ph_d = PH_IDLE;
            load = 1'b0;
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    assign scl_drive_low = (ph_q == PH_LOW);
    assign stretch_flag  = (ph_q == PH_WAITH) && !scl_seen;

    // R7: the stretch flag is only ever seen with SCL released.
    assert_flag_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_flag |-> !scl_drive_low);
    // R2: dropping enable releases SCL at the next edge.
    assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_drive_low);
    // R5: while waiting on a low line the phase does not advance.
    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_WAITH && !scl_seen && enable) |=> (ph_q == PH_WAITH));
    // R4: the high phase is entered only after the line has been seen high.
    assert_high_after_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_WAITH && enable && scl_seen) |=> (ph_q == PH_HIGH));
endmodule

// File: tb/i2c_scl_gen_tb.sv
// Directed bench for i2c_scl_gen: measures phase lengths at the SCL pin model.
module i2c_scl_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] reload_val = 7'd3;
    logic       enable = 1'b0;
    logic       release_req = 1'b1;
    logic       slave_hold = 1'b0;
    logic       scl_line;
    logic       scl_drive_low, rollover, stretch_flag;
    int         n_checks = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    // Wired-AND SCL line: master drive and slave hold.
    assign scl_line = !scl_drive_low && !slave_hold;

    i2c_scl_gen u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reload_val    (reload_val),
        .enable        (enable),
        .release_req   (release_req),
        .scl_in        (scl_line),
        .scl_drive_low (scl_drive_low),
        .rollover      (rollover),
        .stretch_flag  (stretch_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait at negedges for SCL drive to go from released to low.
    task automatic sync_to_low();
        logic prev;
        prev = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!prev && scl_drive_low) return;
            prev = scl_drive_low;
        end
    endtask

    // Measure one period starting at a low edge: low cycles, released cycles, strobes, flag cycles.
    task automatic measure(output int low_n, output int rel_n, output int rolls,
                           output int flags, output int last_low_roll);
        low_n = 1; rel_n = 0; rolls = rollover; flags = stretch_flag; last_low_roll = 0;
        for (int i = 0; i < 2000; i++) begin
            last_low_roll = rollover;
            @(negedge clk);
            if (!scl_drive_low) break;
            low_n++; rolls += rollover; flags += stretch_flag;
        end
        for (int i = 0; i < 2000; i++) begin
            if (scl_drive_low) break;
            rel_n++; rolls += rollover; flags += stretch_flag;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 drive", scl_drive_low, 0);
        check("R1 rollover", rollover, 0);
        check("R1 flag", stretch_flag, 0);
    endtask

    task automatic t_period(input logic [6:0] val, input int n_eff, input string tag);
        int lo, rl, ro, fl, lr;
        reload_val = val;
        sync_to_low();
        sync_to_low();
        measure(lo, rl, ro, fl, lr);
        check({tag, " R3 low cycles"}, lo, 2*n_eff+1);
        check({tag, " R4 released cycles"}, rl, 2*n_eff+4);
        check({tag, " R8 strobes per period"}, ro, 2);
        check({tag, " R8 strobe in last low cycle"}, lr, 1);
        check({tag, " R7 flag cycles"}, fl, 2);
    endtask

    task automatic t_holdoff();
        int lows;
        lows = 0;
        reload_val = 7'd2;
        sync_to_low();
        release_req = 1'b0;
        sync_to_low();
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            lows += scl_drive_low;
        end
        check("R6 held low", lows, 30);
        release_req = 1'b1;
        @(negedge clk);
        check("R6 released after request", scl_drive_low, 0);
    endtask

    task automatic t_stretch(input int hold_n);
        int flags, highs;
        flags = 0; highs = 0;
        reload_val = 7'd3;
        sync_to_low();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!scl_drive_low) break;
        end
        slave_hold = 1'b1;
        for (int i = 0; i < hold_n; i++) begin
            @(negedge clk);
            flags += stretch_flag;
            if (scl_drive_low) check("R5 drive during stretch", 1, 0);
        end
        check("R7 flag during stretch", flags, hold_n);
        slave_hold = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (scl_drive_low) break;
            highs++;
            if (highs > 2 && stretch_flag) check("R7 flag after rise", 1, 0);
        end
        check("R5 high after stretch", highs, 2*3+3);
    endtask

    task automatic t_disable();
        int lows, rolls;
        lows = 0; rolls = 0;
        @(negedge clk);
        enable = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            lows += scl_drive_low; rolls += rollover;
        end
        check("R2 released when disabled", lows, 0);
        check("R2 no strobes when disabled", rolls, 0);
        enable = 1'b1;
        @(negedge clk);
        check("R2 low after enable", scl_drive_low, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b1;
        t_period(7'd3, 3, "N3");
        t_period(7'd5, 5, "N5");
        t_period(7'd1, 1, "N1");
        t_period(7'd0, 1, "R9 N0");
        t_holdoff();
        t_stretch(17);
        t_stretch(4);
        t_disable();
        t_period(7'd3, 3, "after re-enable");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule